// File: doc/BRIEF.md
# AHB Transfer Rule Monitor

This block watches the address and control side of one AHB master, together with the shared ready and response signals, and records every protocol rule it sees broken. It drives nothing onto the bus. Each rule owns one bit of a sticky flag vector. A bit that sets stays set until the clear input is pulsed, so a test or a debug probe can read the vector long after the event. The monitor is synthesizable, so it can sit in silicon or in an emulation build next to a master under suspicion.

Three small trackers share the work. The burst tracker follows the open burst: its type, its beat count, its control values, its start region and the address of its last beat. The response tracker follows the two-cycle SPLIT and RETRY windows and the restart that must come after them. The wait tracker keeps the previous cycle's transfer type, address, ready and response, so it can judge what changed while the bus was stalled. The top module merges their violation pulses into the flag register.

The burst tracker is a state machine with four states. BS_IDLE means no burst is open. BS_UNDEF means an undefined-length INCR burst is open. BS_FIXED means a fixed-length burst is open and still has beats to come. BS_DONE means a fixed-length burst (SINGLE included) has issued all its beats.

All burst transitions happen only on cycles with HREADY high:
- An accepted IDLE leads to BS_IDLE.
- An accepted NONSEQ opens a burst. It goes to BS_DONE for SINGLE, BS_UNDEF for INCR, and BS_FIXED otherwise.
- An accepted SEQ in BS_FIXED moves to BS_DONE when the last beat arrives.
- Every other case holds the current state.

The response tracker has three states:
- RS_NONE means nothing is pending.
- A stalled SPLIT or RETRY cycle leads to RS_HALF. That state marks the second cycle of the response.
- RS_HALF always moves on to RS_PEND, unless it is re-entered.
- RS_PEND waits for the first accepted non-IDLE transfer, then returns to RS_NONE.

Top module: `ahb_rule_monitor`

## Requirements
Encodings used throughout:
- Transfer type: IDLE=0, BUSY=1, NONSEQ=2, SEQ=3.
- Response: OKAY=0, ERROR=1, RETRY=2, SPLIT=3.
- Burst code: SINGLE=0, INCR=1, WRAP4=2, INCR4=3, WRAP8=4, INCR8=5, WRAP16=6, INCR16=7.

A transfer is accepted on a cycle with hready_i high. A flag bit is visible on flags_o one clock edge after the cycle that broke the rule.

- R1: Flag bit 0 sets when, after a cycle with hready_i low showing NONSEQ or SEQ, the transfer type changes. This is exempt when the previous or current response is not OKAY. A change away from IDLE or BUSY is allowed.
- R2: Flag bit 1 sets when, after a cycle with hready_i low showing NONSEQ, SEQ or BUSY, the address changes. This is exempt when the previous or current response is not OKAY. A change away from IDLE is allowed.
- R3: Flag bit 2 sets when an accepted SEQ or BUSY beat of an open burst carries a size, protection, write or burst code that differs from the one recorded at its NONSEQ.
- R4: Flag bit 3 sets when an accepted SEQ beat of an open burst lies in a different 2^BOUND_LOG2-byte region than the burst's NONSEQ address (1 KB by default).
- R5: Flag bit 4 sets when, outside reset, the address is not a multiple of 2^size. This holds for every transfer type, IDLE included.
- R6: Flag bit 5 sets when the transfer type is not IDLE while rst_n is low. This bit survives reset and is cleared only by clr_i.
- R7: Flag bit 6 sets when the cycle after a stalled RETRY or SPLIT cycle has hready_i high and a transfer type other than IDLE.
- R8: Flag bit 7 sets when an accepted BUSY follows the final beat of a fixed-length burst, SINGLE included.
- R9: Flag bit 8 sets when the first accepted non-IDLE transfer after a RETRY or SPLIT response is SEQ or BUSY rather than NONSEQ.
- R10: Flag bit 9 sets when an accepted SEQ or BUSY appears with no burst open. It also sets when an accepted SEQ appears after a fixed-length burst has completed.
- R11: Flag bit 10 sets when an accepted SEQ address differs from the previous beat's address plus 2^size. For wrapping bursts the sum wraps within a block of beats times 2^size bytes.
- R12: Flags are sticky. A cycle with clr_i high sets every bit to 0. Reset sets all bits except bit 5 to 0.
- R13: Legal traffic sets no flag. This covers incrementing, wrapping and BUSY-ended INCR bursts, waited beats, changes away from IDLE or BUSY during a stall, and an ERROR response after which the burst continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clears all flag bits |
| htrans_i | input | 2 | Transfer type |
| haddr_i | input | ADDR_W | Address |
| hburst_i | input | 3 | Burst code |
| hsize_i | input | 3 | Transfer size, log2 of bytes |
| hprot_i | input | 4 | Protection control |
| hwrite_i | input | 1 | Write direction |
| hready_i | input | 1 | Global ready |
| hresp_i | input | 2 | Slave response |
| flags_o | output | 11 | Sticky violation flags, one bit per rule |

## Verification
The bench builds the monitor with a 16-bit address and a 256-byte region (BOUND_LOG2=8). With that setting, an incrementing word burst starting a few beats below 0x100 crosses a region edge in three beats. A full WRAP16 word burst still fits inside one region. Each rule is provoked in isolation where the protocol allows it, and the bench expects exactly one flag bit. RETRY followed by an out-of-place SEQ is the exception: closing the burst with the mandatory IDLE makes R9 and R10 fire together, and the bench expects both bits.

// File: rtl/ahb_mon_pkg.sv
package ahb_mon_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } resp_e;

    localparam logic [2:0] BU_SINGLE = 3'd0;
    localparam logic [2:0] BU_INCR   = 3'd1;
    localparam logic [2:0] BU_WRAP4  = 3'd2;
    localparam logic [2:0] BU_INCR4  = 3'd3;
    localparam logic [2:0] BU_WRAP8  = 3'd4;
    localparam logic [2:0] BU_INCR8  = 3'd5;
    localparam logic [2:0] BU_WRAP16 = 3'd6;
    localparam logic [2:0] BU_INCR16 = 3'd7;

    localparam int RULE_WAIT_TRANS = 0;
    localparam int RULE_WAIT_ADDR  = 1;
    localparam int RULE_CTRL_CHG   = 2;
    localparam int RULE_BOUND      = 3;
    localparam int RULE_ALIGN      = 4;
    localparam int RULE_RST_TRANS  = 5;
    localparam int RULE_RESP_IDLE  = 6;
    localparam int RULE_BUSY_END   = 7;
    localparam int RULE_RESTART    = 8;
    localparam int RULE_NO_BURST   = 9;
    localparam int RULE_SEQ_ADDR   = 10;
    localparam int NUM_RULES       = 11;

    typedef struct packed {
        logic [2:0] size;
        logic [3:0] prot;
        logic       write;
        logic [2:0] burst;
    } ctrl_t;

    // Number of beats in a burst code; 0 stands for undefined length.
    function automatic logic [4:0] beats_of(input logic [2:0] code);
        logic [4:0] n;
        unique case (code)
            BU_SINGLE:          n = 5'd1;
            BU_INCR:            n = 5'd0;
            BU_WRAP4, BU_INCR4: n = 5'd4;
            BU_WRAP8, BU_INCR8: n = 5'd8;
            default:            n = 5'd16;
        endcase
        return n;
    endfunction

    function automatic logic is_wrap(input logic [2:0] code);
        return (code == BU_WRAP4) || (code == BU_WRAP8) || (code == BU_WRAP16);
    endfunction

    function automatic logic is_sr(input logic [1:0] resp);
        return (resp == RSP_RETRY) || (resp == RSP_SPLIT);
    endfunction

endpackage

// File: rtl/ahb_mon_burst.sv
module ahb_mon_burst
    import ahb_mon_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BOUND_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        htrans_i,
    input  logic [ADDR_W-1:0] haddr_i,
    input  ctrl_t             ctrl_i,
    input  logic              hready_i,
    output logic              v_ctrl_o,
    output logic              v_bound_o,
    output logic              v_busy_end_o,
    output logic              v_no_burst_o,
    output logic              v_seq_addr_o
);

    localparam int HI_W = ADDR_W - BOUND_LOG2;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_UNDEF,
        BS_FIXED,
        BS_DONE
    } bstate_e;

    bstate_e           state_q, state_d;
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] last_q;
    logic [HI_W-1:0]   start_hi_q;
    logic [4:0]        beat_q;

    trans_e            tr;
    logic              accept;
    logic              open_burst;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] wrap_mask;
    logic [ADDR_W-1:0] next_addr;

    assign tr         = trans_e'(htrans_i);
    assign accept     = rst_n && hready_i;
    assign open_burst = (state_q == BS_UNDEF) || (state_q == BS_FIXED);
    assign step       = ADDR_W'(1) << ctrl_q.size;
    assign wrap_mask  = (ADDR_W'(beats_of(ctrl_q.burst)) * step) - ADDR_W'(1);
    assign next_addr  = is_wrap(ctrl_q.burst)
                      ? ((last_q & ~wrap_mask) | ((last_q + step) & wrap_mask))
                      : (last_q + step);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (hready_i) begin
            unique case (tr)
                TR_IDLE: state_d = BS_IDLE;
                TR_NONSEQ: begin
                    if (ctrl_i.burst == BU_SINGLE)    state_d = BS_DONE;
                    else if (ctrl_i.burst == BU_INCR) state_d = BS_UNDEF;
                    else                              state_d = BS_FIXED;
                end
                TR_SEQ: begin
                    if (state_q == BS_FIXED && (beat_q + 5'd1) == beats_of(ctrl_q.burst))
                        state_d = BS_DONE;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State and context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= BS_IDLE;
            ctrl_q     <= '0;
            last_q     <= '0;
            start_hi_q <= '0;
            beat_q     <= '0;
        end else begin
            state_q <= state_d;
            if (hready_i && tr == TR_NONSEQ) begin
                ctrl_q     <= ctrl_i;
                last_q     <= haddr_i;
                start_hi_q <= haddr_i[ADDR_W-1:BOUND_LOG2];
                beat_q     <= 5'd1;
            end else if (hready_i && tr == TR_SEQ && open_burst) begin
                last_q <= haddr_i;
                beat_q <= beat_q + 5'd1;
            end
        end
    end

    // Output (violation) logic
    always_comb begin
        v_ctrl_o     = 1'b0;
        v_bound_o    = 1'b0;
        v_busy_end_o = 1'b0;
        v_no_burst_o = 1'b0;
        v_seq_addr_o = 1'b0;
        if (accept) begin
            unique case (state_q)
                BS_IDLE: v_no_burst_o = (tr == TR_SEQ) || (tr == TR_BUSY);
                BS_DONE: begin
                    v_no_burst_o = (tr == TR_SEQ);
                    v_busy_end_o = (tr == TR_BUSY);
                end
                default: begin
                    v_ctrl_o     = ((tr == TR_SEQ) || (tr == TR_BUSY)) && (ctrl_i != ctrl_q);
                    v_bound_o    = (tr == TR_SEQ) && (haddr_i[ADDR_W-1:BOUND_LOG2] != start_hi_q);
                    v_seq_addr_o = (tr == TR_SEQ) && (haddr_i != next_addr);
                end
            endcase
        end
    end

    a_r10_open_after_nonseq: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hready_i) && $past(htrans_i) == TR_NONSEQ
         && $past(ctrl_i.burst) != BU_SINGLE)
        |-> (state_q == BS_UNDEF || state_q == BS_FIXED));

    a_r8_single_is_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hready_i) && $past(htrans_i) == TR_NONSEQ
         && $past(ctrl_i.burst) == BU_SINGLE)
        |-> (state_q == BS_DONE));

endmodule

// File: rtl/ahb_mon_resp.sv
module ahb_mon_resp
    import ahb_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] htrans_i,
    input  logic       hready_i,
    input  logic [1:0] hresp_i,
    output logic       v_resp_idle_o,
    output logic       v_restart_o
);

    typedef enum logic [1:0] {
        RS_NONE,
        RS_HALF,
        RS_PEND
    } rstate_e;

    rstate_e st_q, st_d;
    trans_e  tr;
    logic    first_cycle;

    assign tr          = trans_e'(htrans_i);
    assign first_cycle = !hready_i && is_sr(hresp_i);

    always_comb begin
        st_d = st_q;
        if (first_cycle) begin
            st_d = RS_HALF;
        end else begin
            unique case (st_q)
                RS_HALF: st_d = RS_PEND;
                RS_PEND: if (hready_i && tr != TR_IDLE) st_d = RS_NONE;
                default: st_d = RS_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_NONE;
        else        st_q <= st_d;
    end

    always_comb begin
        v_resp_idle_o = 1'b0;
        v_restart_o   = 1'b0;
        if (rst_n && hready_i) begin
            unique case (st_q)
                RS_HALF: v_resp_idle_o = (tr != TR_IDLE);
                RS_PEND: v_restart_o   = (tr == TR_SEQ) || (tr == TR_BUSY);
                default: ;
            endcase
        end
    end

    a_r7_half_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_HALF) |-> ($past(!hready_i) && is_sr($past(hresp_i))));

    a_r9_pend_after_half: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st_q) == RS_HALF
         && !($past(!hready_i) && is_sr($past(hresp_i))))
        |-> (st_q == RS_PEND));

endmodule

// File: rtl/ahb_mon_wait.sv
module ahb_mon_wait
    import ahb_mon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        htrans_i,
    input  logic [ADDR_W-1:0] haddr_i,
    input  logic [2:0]        hsize_i,
    input  logic              hready_i,
    input  logic [1:0]        hresp_i,
    output logic              v_wait_trans_o,
    output logic              v_wait_addr_o,
    output logic              v_align_o
);

    trans_e            prev_tr_q;
    logic [ADDR_W-1:0] prev_addr_q;
    logic              prev_rdy_q;
    logic [1:0]        prev_resp_q;

    trans_e            tr;
    logic              exempt;
    logic [ADDR_W-1:0] align_mask;

    assign tr         = trans_e'(htrans_i);
    assign exempt     = (prev_resp_q != RSP_OKAY) || (hresp_i != RSP_OKAY);
    assign align_mask = (ADDR_W'(1) << hsize_i) - ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tr_q   <= TR_IDLE;
            prev_addr_q <= '0;
            prev_rdy_q  <= 1'b1;
            prev_resp_q <= RSP_OKAY;
        end else begin
            prev_tr_q   <= tr;
            prev_addr_q <= haddr_i;
            prev_rdy_q  <= hready_i;
            prev_resp_q <= hresp_i;
        end
    end

    always_comb begin
        v_wait_trans_o = rst_n && !prev_rdy_q && !exempt
                       && (prev_tr_q == TR_NONSEQ || prev_tr_q == TR_SEQ)
                       && (tr != prev_tr_q);
        v_wait_addr_o  = rst_n && !prev_rdy_q && !exempt
                       && (prev_tr_q != TR_IDLE)
                       && (haddr_i != prev_addr_q);
        v_align_o      = rst_n && ((haddr_i & align_mask) != '0);
    end

endmodule

// File: rtl/ahb_rule_monitor.sv
module ahb_rule_monitor
    import ahb_mon_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BOUND_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [1:0]        htrans_i,
    input  logic [ADDR_W-1:0] haddr_i,
    input  logic [2:0]        hburst_i,
    input  logic [2:0]        hsize_i,
    input  logic [3:0]        hprot_i,
    input  logic              hwrite_i,
    input  logic              hready_i,
    input  logic [1:0]        hresp_i,
    output logic [10:0]       flags_o
);

    logic [NUM_RULES-1:0] flags_q;
    logic [NUM_RULES-1:0] viol;
    ctrl_t                ctrl;

    assign ctrl = '{size: hsize_i, prot: hprot_i, write: hwrite_i, burst: hburst_i};

    ahb_mon_burst #(
        .ADDR_W     (ADDR_W),
        .BOUND_LOG2 (BOUND_LOG2)
    ) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .htrans_i     (htrans_i),
        .haddr_i      (haddr_i),
        .ctrl_i       (ctrl),
        .hready_i     (hready_i),
        .v_ctrl_o     (viol[RULE_CTRL_CHG]),
        .v_bound_o    (viol[RULE_BOUND]),
        .v_busy_end_o (viol[RULE_BUSY_END]),
        .v_no_burst_o (viol[RULE_NO_BURST]),
        .v_seq_addr_o (viol[RULE_SEQ_ADDR])
    );

    ahb_mon_resp u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .htrans_i      (htrans_i),
        .hready_i      (hready_i),
        .hresp_i       (hresp_i),
        .v_resp_idle_o (viol[RULE_RESP_IDLE]),
        .v_restart_o   (viol[RULE_RESTART])
    );

    ahb_mon_wait #(
        .ADDR_W (ADDR_W)
    ) u_wait (
        .clk            (clk),
        .rst_n          (rst_n),
        .htrans_i       (htrans_i),
        .haddr_i        (haddr_i),
        .hsize_i        (hsize_i),
        .hready_i       (hready_i),
        .hresp_i        (hresp_i),
        .v_wait_trans_o (viol[RULE_WAIT_TRANS]),
        .v_wait_addr_o  (viol[RULE_WAIT_ADDR]),
        .v_align_o      (viol[RULE_ALIGN])
    );

    // The reset rule is judged by the top itself while the trackers are held.
    assign viol[RULE_RST_TRANS] = 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q                 <= '0;
            flags_q[RULE_RST_TRANS] <= (flags_q[RULE_RST_TRANS] & ~clr_i)
                                     | (htrans_i != TR_IDLE);
        end else if (clr_i) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_q | viol;
        end
    end

    assign flags_o = flags_q;

    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_i) |-> ((flags_o & $past(flags_o)) == $past(flags_o)));

    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_i) && $past(rst_n)) |-> (flags_o == '0));

endmodule

// File: tb/ahb_rule_monitor_tb.sv
module ahb_rule_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clr_i;
    logic [1:0]    htrans_i;
    logic [AW-1:0] haddr_i;
    logic [2:0]    hburst_i;
    logic [2:0]    hsize_i;
    logic [3:0]    hprot_i;
    logic          hwrite_i;
    logic          hready_i;
    logic [1:0]    hresp_i;
    logic [10:0]   flags_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [1:0] I = 2'd0, B = 2'd1, N = 2'd2, S = 2'd3;
    localparam logic [1:0] OK = 2'd0, ER = 2'd1, RT = 2'd2;
    localparam logic [2:0] SGL = 3'd0, INC = 3'd1, WR4 = 3'd2, INC4 = 3'd3;

    always #(CLK_PERIOD/2) clk = ~clk;

    ahb_rule_monitor #(
        .ADDR_W     (AW),
        .BOUND_LOG2 (8)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .htrans_i (htrans_i),
        .haddr_i  (haddr_i),
        .hburst_i (hburst_i),
        .hsize_i  (hsize_i),
        .hprot_i  (hprot_i),
        .hwrite_i (hwrite_i),
        .hready_i (hready_i),
        .hresp_i  (hresp_i),
        .flags_o  (flags_o)
    );

    task automatic drive(input logic [1:0] tr, input logic [AW-1:0] a,
                         input logic [2:0] bu, input logic [2:0] sz,
                         input logic rdy, input logic [1:0] rsp);
        htrans_i = tr; haddr_i = a; hburst_i = bu; hsize_i = sz;
        hready_i = rdy; hresp_i = rsp;
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic [10:0] exp);
        total++;
        if (flags_o !== exp) begin
            bad++;
            $display("FAIL %s: flags actual=%b expected=%b", req, flags_o, exp);
        end
    endtask

    task automatic clear_all();
        clr_i = 1'b1;
        drive(I, 16'h0, SGL, 3'd2, 1'b1, OK);
        clr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; clr_i = 1'b1; hprot_i = 4'b0011; hwrite_i = 1'b0;
        drive(I, 16'h0, SGL, 3'd2, 1'b1, OK);
        drive(I, 16'h0, SGL, 3'd2, 1'b1, OK);
        clr_i = 1'b0;
        check("R12 reset state", 11'h000);
        drive(B, 16'h0, SGL, 3'd2, 1'b1, OK);
        check("R6 busy in reset", 11'h020);
        rst_n = 1'b1;
        drive(I, 16'h0, SGL, 3'd2, 1'b1, OK);
        drive(I, 16'h0, SGL, 3'd2, 1'b1, OK);
        check("R6 survives reset release", 11'h020);
        clear_all();
        check("R12 clear", 11'h000);
    endtask

    task automatic t_legal();
        drive(N, 16'h040, INC4, 3'd2, 1'b1, OK);
        drive(S, 16'h044, INC4, 3'd2, 1'b1, OK);
        drive(S, 16'h048, INC4, 3'd2, 1'b1, OK);
        drive(S, 16'h04C, INC4, 3'd2, 1'b1, OK);
        drive(I, 16'h04C, SGL,  3'd2, 1'b1, OK);
        drive(N, 16'h038, WR4,  3'd2, 1'b1, OK);
        drive(S, 16'h03C, WR4,  3'd2, 1'b1, OK);
        drive(S, 16'h030, WR4,  3'd2, 1'b1, OK);
        drive(S, 16'h034, WR4,  3'd2, 1'b1, OK);
        drive(I, 16'h034, SGL,  3'd2, 1'b1, OK);
        check("R13 incr and wrap bursts", 11'h000);
        drive(N, 16'h080, INC,  3'd2, 1'b1, OK);
        drive(B, 16'h084, INC,  3'd2, 1'b0, OK);
        drive(S, 16'h084, INC,  3'd2, 1'b1, OK);
        drive(B, 16'h088, INC,  3'd2, 1'b1, OK);
        drive(I, 16'h088, SGL,  3'd2, 1'b1, OK);
        drive(I, 16'h0A0, SGL,  3'd2, 1'b0, OK);
        drive(N, 16'h0A4, SGL,  3'd2, 1'b0, OK);
        drive(N, 16'h0A4, SGL,  3'd2, 1'b1, OK);
        drive(I, 16'h0A4, SGL,  3'd2, 1'b1, OK);
        check("R13 busy-ended incr and waited changes", 11'h000);
        drive(N, 16'h090, INC,  3'd2, 1'b1, OK);
        drive(S, 16'h094, INC,  3'd2, 1'b0, ER);
        drive(S, 16'h094, INC,  3'd2, 1'b1, ER);
        drive(S, 16'h098, INC,  3'd2, 1'b1, OK);
        drive(I, 16'h098, SGL,  3'd2, 1'b1, OK);
        check("R13 burst continues after error", 11'h000);
    endtask

    task automatic t_wait_trans();
        clear_all();
        drive(N, 16'h100, INC, 3'd2, 1'b0, OK);
        drive(I, 16'h100, SGL, 3'd2, 1'b1, OK);
        check("R1 nonseq dropped while waited", 11'h001);
    endtask

    task automatic t_wait_addr();
        clear_all();
        drive(N, 16'h200, SGL, 3'd2, 1'b0, OK);
        drive(N, 16'h204, SGL, 3'd2, 1'b1, OK);
        drive(I, 16'h204, SGL, 3'd2, 1'b1, OK);
        check("R2 address moved while waited", 11'h002);
    endtask

    task automatic t_ctrl();
        clear_all();
        drive(N, 16'h300, INC4, 3'd2, 1'b1, OK);
        drive(S, 16'h304, INC4, 3'd1, 1'b1, OK);
        drive(I, 16'h304, SGL,  3'd2, 1'b1, OK);
        check("R3 size changed mid-burst", 11'h004);
    endtask

    task automatic t_bound();
        clear_all();
        drive(N, 16'h0F8, INC, 3'd2, 1'b1, OK);
        drive(S, 16'h0FC, INC, 3'd2, 1'b1, OK);
        drive(S, 16'h100, INC, 3'd2, 1'b1, OK);
        drive(I, 16'h100, SGL, 3'd2, 1'b1, OK);
        check("R4 region crossed", 11'h008);
    endtask

    task automatic t_align();
        clear_all();
        drive(I, 16'h002, SGL, 3'd2, 1'b1, OK);
        drive(I, 16'h000, SGL, 3'd2, 1'b1, OK);
        check("R5 misaligned idle", 11'h010);
    endtask

    task automatic t_resp_idle();
        clear_all();
        drive(N, 16'h400, SGL, 3'd2, 1'b1, OK);
        drive(N, 16'h404, SGL, 3'd2, 1'b0, RT);
        drive(N, 16'h404, SGL, 3'd2, 1'b1, RT);
        drive(I, 16'h404, SGL, 3'd2, 1'b1, OK);
        check("R7 no idle in second response cycle", 11'h040);
    endtask

    task automatic t_restart();
        clear_all();
        drive(N, 16'h500, INC4, 3'd2, 1'b1, OK);
        drive(S, 16'h504, INC4, 3'd2, 1'b0, RT);
        drive(I, 16'h508, INC4, 3'd2, 1'b1, RT);
        drive(S, 16'h504, INC4, 3'd2, 1'b1, OK);
        drive(I, 16'h504, SGL,  3'd2, 1'b1, OK);
        check("R9 and R10 seq restart", 11'h300);
    endtask

    task automatic t_busy_end();
        clear_all();
        drive(N, 16'h600, INC4, 3'd2, 1'b1, OK);
        drive(S, 16'h604, INC4, 3'd2, 1'b1, OK);
        drive(S, 16'h608, INC4, 3'd2, 1'b1, OK);
        drive(S, 16'h60C, INC4, 3'd2, 1'b1, OK);
        drive(B, 16'h610, INC4, 3'd2, 1'b1, OK);
        drive(I, 16'h610, SGL,  3'd2, 1'b1, OK);
        check("R8 busy after incr4", 11'h080);
        clear_all();
        drive(N, 16'h620, SGL, 3'd2, 1'b1, OK);
        drive(B, 16'h624, SGL, 3'd2, 1'b1, OK);
        drive(I, 16'h624, SGL, 3'd2, 1'b1, OK);
        check("R8 busy after single", 11'h080);
    endtask

    task automatic t_no_burst();
        clear_all();
        drive(S, 16'h700, INC, 3'd2, 1'b1, OK);
        drive(I, 16'h700, SGL, 3'd2, 1'b1, OK);
        check("R10 seq with no burst", 11'h200);
    endtask

    task automatic t_seq_addr();
        clear_all();
        drive(N, 16'h800, INC4, 3'd2, 1'b1, OK);
        drive(S, 16'h808, INC4, 3'd2, 1'b1, OK);
        drive(I, 16'h808, SGL,  3'd2, 1'b1, OK);
        check("R11 skipped address", 11'h400);
        for (int k = 0; k < 3; k++) drive(I, 16'h0, SGL, 3'd2, 1'b1, OK);
        check("R12 flag stays set", 11'h400);
        clear_all();
        check("R12 clear after sticky", 11'h000);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_legal();
        t_wait_trans();
        t_wait_addr();
        t_ctrl();
        t_bound();
        t_align();
        t_resp_idle();
        t_restart();
        t_busy_end();
        t_no_burst();
        t_seq_addr();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule